// File: doc/BRIEF.md
# Two-Channel Timer with Buffered PWM

This block is a free-running up-counter shared by two channels. The counter wraps at a programmable limit. Each channel works in one of two modes. In input-capture mode it snapshots the counter on a chosen edge of its capture pin. In output-compare mode it drives a PWM pin: the pin goes high at the counter wrap and low at the compare match. Both events raise sticky flags, and any flag whose enable bit is set drives the interrupt request.

A link bit in channel 0's control register joins the two channels into one double-buffered PWM output on `pwm_out[0]`. Channel 0's compare value governs the first period. After that, software writes the new duty into whichever value register is idle. The swap happens at the next wrap, so a period never mixes two duty values. Two control bits give exact 0% duty (wrap toggling off) and exact 100% duty (maximum-duty and wrap toggling both on).

The bus is a simple register bus. Writes take effect on the clock edge. Read data is combinational from `addr`, and `rd_en` marks a read that counts for the flag-clearing handshake.

Top module: `tim2ch_pwm`

Register map (addresses on `addr`): 0 status (bit 0 wrap flag, bit 1 wrap interrupt enable), 1 counter (read only), 2 limit (reset value all ones), 3 channel 0 control, 4 channel 0 value, 5 channel 1 control, 6 channel 1 value. Channel control bits: bit 0 flag, bit 1 interrupt enable, bit 2 compare mode (0 = capture), bit 3 capture edge (1 rising, 0 falling), bit 4 link (channel 0 only), bit 5 toggle on wrap, bit 6 maximum duty.

## Requirements
- R1: The counter counts up by one each clock. In the cycle after it equals the limit register it reads 0.
- R2: The wrap flag (status bit 0) sets in the cycle after the counter equals the limit. The wrap flag contributes to `irq` only while status bit 1 is 1.
- R3: In compare mode with toggle-on-wrap set, the pin goes high the cycle after a wrap and low the cycle after the counter equals the channel value. If both happen in the same cycle, the match wins. So with limit M and value V < M, the pin is high V+1 of every M+1 cycles. A match also sets the channel flag (control bit 0).
- R4: With toggle-on-wrap clear, the compare pin stays low (0% duty).
- R5: With maximum duty and toggle-on-wrap both set, the compare pin is held high (100% duty).
- R6: In capture mode, on the selected edge of `cap_in[c]`, the counter value present in that cycle is latched into the channel value register and the channel flag sets. The opposite edge has no effect.
- R7: A flag clears only on a write of 0 to it that follows a read (with `rd_en`) of its register while it was set. A write of 0 with no prior read, or a write of 1, leaves it set.
- R8: If the flag's event recurs between that read and the write, the write leaves the flag set.
- R9: `irq` is the OR of every flag ANDed with its own enable.
- R10: With the link bit set, `pwm_out[0]` is driven from channel 0's control bits, channel 0's value governs the first period, and `pwm_out[1]` stays low.
- R11: In linked mode, a write to the idle channel's value register hands control to that channel at the next wrap, so the new duty starts on a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms flag clearing) |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr` |
| cap_in | input | 2 | Capture inputs, one per channel |
| pwm_out | output | 2 | Compare/PWM pins, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
A table of limit/compare pairs is run in compare mode. The pairs cover a value inside the period, a value of zero, a value equal to the limit and a value beyond it. The high time counted over one period tells the ordinary case apart from the match-wins-over-wrap case and the never-matches case. Separate patterns cover the following:
- toggle-off and maximum-duty settings;
- capture on rising versus falling edges;
- flag clearing with and without the prior read, and with a repeat event in between;
- linked mode, where successive writes to the idle value register must move the measured duty only on a period boundary.

// File: rtl/tim2ch_pwm.sv
module tim2ch_pwm #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [1:0]    cap_in,
  output logic [1:0]    pwm_out,
  output logic          irq
);
  localparam logic [2:0] A_STAT = 3'd0, A_CNT = 3'd1, A_LIM = 3'd2;

  logic [CW-1:0] cnt, lim;
  logic [CW-1:0] val [2];
  logic          wf, wie, warm;
  logic [1:0]    cf, cie, coc, crise, ctov, cmax, carm, cap_q;
  logic          link, act, pend;

  logic          wrap;
  logic [1:0]    edge_ev, cap_ev, cmp_ev, pin_en, pin_match, pin_nx;
  logic          lmatch;

  assign wrap   = (cnt == lim);
  assign lmatch = link && (cnt == (act ? val[1] : val[0]));

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      edge_ev[c] = crise[c] ? (cap_in[c] & ~cap_q[c]) : (~cap_in[c] & cap_q[c]);
      cap_ev[c]  = ~coc[c] & ~link & edge_ev[c];
      cmp_ev[c]  = link ? (lmatch && (act == c[0])) : (coc[c] && cnt == val[c]);
    end
    pin_en    = {coc[1] & ~link, coc[0] | link};
    pin_match = {cmp_ev[1], link ? lmatch : cmp_ev[0]};
    for (int c = 0; c < 2; c++) begin
      if (!pin_en[c])                pin_nx[c] = 1'b0;
      else if (ctov[c] && cmax[c])   pin_nx[c] = 1'b1;
      else if (pin_match[c])         pin_nx[c] = 1'b0;
      else if (wrap && ctov[c])      pin_nx[c] = 1'b1;
      else                           pin_nx[c] = pwm_out[c];
    end
  end

  assign irq = (wf & wie) | |(cf & cie);

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: rdata[1:0] = {wie, wf};
      A_CNT:  rdata = cnt;
      A_LIM:  rdata = lim;
      3'd3:   rdata[6:0] = {cmax[0], ctov[0], link, crise[0], coc[0], cie[0], cf[0]};
      3'd4:   rdata = val[0];
      3'd5:   rdata[6:0] = {cmax[1], ctov[1], 1'b0, crise[1], coc[1], cie[1], cf[1]};
      3'd6:   rdata = val[1];
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; lim <= '1; wf <= 1'b0; wie <= 1'b0; warm <= 1'b0;
      cf <= '0; cie <= '0; coc <= '0; crise <= '0; ctov <= '0; cmax <= '0; carm <= '0;
      cap_q <= '0; link <= 1'b0; act <= 1'b0; pend <= 1'b0; pwm_out <= '0;
      val[0] <= '0; val[1] <= '0;
    end else begin
      cnt     <= wrap ? '0 : cnt + 1'b1;
      cap_q   <= cap_in;
      pwm_out <= pin_nx;
      if (wr_en && addr == A_LIM) lim <= wdata;

      if (wrap) begin
        wf <= 1'b1; warm <= 1'b0;
      end else if (wr_en && addr == A_STAT) begin
        if (warm && !wdata[0]) wf <= 1'b0;
        warm <= 1'b0;
      end else if (rd_en && addr == A_STAT && wf) warm <= 1'b1;
      if (wr_en && addr == A_STAT) wie <= wdata[1];

      for (int c = 0; c < 2; c++) begin
        if (cmp_ev[c] || cap_ev[c]) begin
          cf[c] <= 1'b1; carm[c] <= 1'b0;
        end else if (wr_en && addr == 3'(3 + 2*c)) begin
          if (carm[c] && !wdata[0]) cf[c] <= 1'b0;
          carm[c] <= 1'b0;
        end else if (rd_en && addr == 3'(3 + 2*c) && cf[c]) carm[c] <= 1'b1;
        if (wr_en && addr == 3'(3 + 2*c)) begin
          cie[c] <= wdata[1]; coc[c] <= wdata[2]; crise[c] <= wdata[3];
          ctov[c] <= wdata[5]; cmax[c] <= wdata[6];
        end
        if (cap_ev[c])                          val[c] <= cnt;
        else if (wr_en && addr == 3'(4 + 2*c))  val[c] <= wdata;
      end
      if (wr_en && addr == 3'd3) link <= wdata[4];

      if (!link) begin
        act <= 1'b0; pend <= 1'b0;
      end else if (wrap && pend) begin
        act <= ~act; pend <= 1'b0;
      end else if (wr_en && addr == (act ? 3'd4 : 3'd6)) pend <= 1'b1;
    end
  end

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> cnt == '0);
  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> wf);
  p_cmp_low_r3:   assert property (@(posedge clk) disable iff (!rst_n)
                    (cmp_ev[0] && !link && !(ctov[0] && cmax[0])) |=> !pwm_out[0]);
  p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    (coc[0] && !link && !ctov[0] && !pwm_out[0]) |=> !pwm_out[0]);
  p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    (pin_en[0] && ctov[0] && cmax[0]) |=> pwm_out[0]);
  p_cap_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    cap_ev[0] |=> (val[0] == $past(cnt) && cf[0]));
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    (wf && !(wr_en && addr == A_STAT)) |=> wf);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    (!wie && cie == 2'b00) |-> !irq);
  p_link_pin1_r10: assert property (@(posedge clk) disable iff (!rst_n) link |=> !pwm_out[1]);
endmodule

// File: tb/tim2ch_pwm_tb.sv
module tim2ch_pwm_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{'{9, 3, 4}, '{9, 0, 1}, '{9, 9, 0}, '{9, 12, 10}, '{4, 2, 3}, '{15, 7, 8}};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0] cap_in = '0, pwm_out;
  logic irq;
  int n_run = 0, n_fail = 0;

  tim2ch_pwm #(.CW(16)) dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cap_in = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic high_count(input int lim, input int bit_i, output int hc);
    repeat ((lim + 1) * 3) @(negedge clk);
    hc = 0;
    for (int i = 0; i <= lim; i++) begin
      @(negedge clk);
      if (pwm_out[bit_i]) hc++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d, v;
    int hc, prev, bad;
    bit seen0;

    do_reset();
    @(negedge clk);
    check(pwm_out == 2'b00 && irq == 1'b0, "R1 reset pins", int'({pwm_out, irq}), 0);
    peek(3'd2, d); check(d == 16'hFFFF, "R1 reset limit", d, 16'hFFFF);
    peek(3'd3, d); check(d == 0, "R10 reset ch0 control", d, 0);

    // R1: counter wrap
    do_reset(); wr(3'd2, 16'd5);
    addr = 3'd1; #1 prev = rdata; bad = 0; seen0 = 1'b0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); #1;
      if (int'(rdata) != ((prev == 5) ? 0 : prev + 1)) bad++;
      if (rdata == 0) seen0 = 1'b1;
      prev = rdata;
    end
    check(bad == 0 && seen0, "R1 count and wrap", bad, 0);

    // R3: duty table
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(3'd2, 16'(VEC[k][0])); wr(3'd4, 16'(VEC[k][1])); wr(3'd3, 16'h0024);
      high_count(VEC[k][0], 0, hc);
      check(hc == VEC[k][2], "R3 duty high cycles", hc, VEC[k][2]);
    end
    do_reset(); wr(3'd2, 16'd9); wr(3'd4, 16'd3); wr(3'd3, 16'h0024);
    repeat (12) @(negedge clk);
    peek(3'd3, d); check(d[0] == 1'b1, "R3 compare flag", d[0], 1);

    // R4: toggle off -> 0%
    do_reset(); wr(3'd2, 16'd9); wr(3'd4, 16'd3); wr(3'd3, 16'h0004);
    high_count(9, 0, hc); check(hc == 0, "R4 zero duty", hc, 0);
    // R5: max duty
    do_reset(); wr(3'd2, 16'd9); wr(3'd4, 16'd3); wr(3'd3, 16'h0064);
    high_count(9, 0, hc); check(hc == 10, "R5 full duty", hc, 10);

    // R2 / R7 / R9: wrap flag handshake and irq
    do_reset(); wr(3'd2, 16'd8);
    repeat (12) @(negedge clk);
    wr(3'd2, 16'd60000);
    peek(3'd0, d); check(d[0] == 1'b1 && irq == 1'b0, "R2 flag set, irq masked", int'({d[0], irq}), 2);
    wr(3'd0, 16'h0002);
    peek(3'd0, d); check(d[0] == 1'b1, "R7 write 0 without read keeps flag", d[0], 1);
    check(irq == 1'b1, "R9 irq with enabled flag", irq, 1);
    wr(3'd0, 16'h0003);
    peek(3'd0, d); check(d[0] == 1'b1, "R7 write 1 keeps flag", d[0], 1);
    rd(3'd0, d); wr(3'd0, 16'h0002);
    peek(3'd0, d); check(d[0] == 1'b0, "R7 read then write 0 clears", d[0], 0);
    check(irq == 1'b0, "R9 irq drops with flag", irq, 0);

    // R8: event between read and write
    do_reset(); wr(3'd2, 16'd8);
    repeat (12) @(negedge clk);
    rd(3'd0, d);
    repeat (12) @(negedge clk);
    wr(3'd2, 16'd60000); wr(3'd0, 16'h0000);
    peek(3'd0, d); check(d[0] == 1'b1, "R8 event during handshake keeps flag", d[0], 1);

    // R6: capture rising
    do_reset(); wr(3'd3, 16'h000A);
    repeat (5) @(negedge clk);
    cap_in[0] = 1'b1; peek(3'd1, v);
    @(negedge clk); peek(3'd4, d);
    check(d == v, "R6 rising capture value", d, v);
    peek(3'd3, d); check(d[0] == 1'b1 && irq == 1'b1, "R6 capture flag and R9 irq", int'({d[0], irq}), 3);
    // R6: falling edge selected
    do_reset(); wr(3'd3, 16'h0000);
    repeat (4) @(negedge clk);
    cap_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    peek(3'd3, d); check(d[0] == 1'b0, "R6 opposite edge ignored (flag)", d[0], 0);
    peek(3'd4, d); check(d == 0, "R6 opposite edge ignored (value)", d, 0);
    cap_in[0] = 1'b0; peek(3'd1, v);
    @(negedge clk); peek(3'd4, d);
    check(d == v, "R6 falling capture value", d, v);

    // R10 / R11: linked buffered PWM
    do_reset(); wr(3'd2, 16'd9); wr(3'd4, 16'd2); wr(3'd6, 16'd1); wr(3'd5, 16'h0024);
    wr(3'd3, 16'h0034);
    high_count(9, 0, hc); check(hc == 3, "R10 channel 0 value governs first", hc, 3);
    high_count(9, 1, hc); check(hc == 0, "R10 pin 1 held low", hc, 0);
    wr(3'd6, 16'd6);
    high_count(9, 0, hc); check(hc == 7, "R11 swap to channel 1", hc, 7);
    wr(3'd4, 16'd4);
    high_count(9, 0, hc); check(hc == 5, "R11 swap back to channel 0", hc, 5);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule